// File: doc/BRIEF.md
# Indexed Parallel Register Port with Windowed Frame-Buffer Addressing

This block is the host-facing slave of a display controller. A host processor talks to it over an 8080-style strobed byte bus made up of an active-low select, a register/data select line, separate write and read strobes and an 8-bit data bus. Every internal word is 16 bits wide and crosses the bus as two byte transfers, high byte first. A word written with the select line low only picks a register through a 7-bit index. Words moved with the select line high go to or come from the register that the index names.

The block holds the scan-mode register, the contrast register, the horizontal and vertical window limits and a per-bit write protect mask. It also holds an address counter that walks a rectangular window of a frame buffer. Pixel words written through the data register come out on a frame-buffer write port. Each word carries its address and a per-bit write enable, and after every stored word the counter moves to the next cell of the window. Status and identification words can be read back.

All bus pins are asynchronous to the block clock. They pass through two synchronizing flops, and a transfer is recognised on the rising edge of a strobe while the select is low.

Top module: `disp_reg_port`

## Requirements
- R1: After reset `fb_we` is 0, `fb_addr` is 0, `db_oe` is 0 and `db_out` is 0. The scan-mode register reads 0x0030 and the horizontal window register reads 0xFF00.
- R2: A word is committed on the rising write strobe of its second byte, and the first byte is the high byte. A resulting `fb_we` pulse lasts exactly one clock and is seen after the third rising clock edge that follows the strobe rise.
- R3: A word written with `rs`=0 sets the index to bits [6:0] of the word. Bit 7 and the whole high byte have no effect.
- R4: A read with `rs`=0 returns `raster_row` in bits [15:8], 0 in bit 7 and the contrast value in bits [6:0].
- R5: A read with `rs`=1 at index 0x00 returns 0x0766.
- R6: A write to index 0x22 drives `fb_wdata` with the word and `fb_addr` with the counter. It also drives `fb_bit_en` with the inverse of the mask at index 0x20, where a set mask bit protects that bit.
- R7: A write to index 0x21 loads the counter. `fb_addr` bits [15:8] are the vertical position and bits [7:0] the horizontal position.
- R8: In index 0x05, bit 4 sets the horizontal direction and bit 5 the vertical direction (1 counts up, 0 counts down). Bit 3 = 0 makes the counter advance horizontally after each stored word.
- R9: Index 0x16 holds the horizontal window end in [15:8] and start in [7:0], and index 0x17 does the same vertically. When the counter steps past the edge it is moving toward, it jumps to the opposite edge and moves the other axis one step, with that axis wrapping in the same way.
- R10: With bit 3 of index 0x05 set, the counter advances vertically first and moves horizontally on a vertical wrap.
- R11: A read of index 0x22 returns `fb_rdata` and does not move the counter. Reads of 0x04, 0x05, 0x16, 0x17 and 0x20 return the stored fields with unused bits 0. Index 0x04 keeps bits [10:8] and [6:0].
- R12: Strobes given while `cs_n` is high change no register and cause no `fb_we`.
- R13: `db_oe` is high only while the synchronized select and read strobe are both low, and `db_out` is 0 whenever `db_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cs_n | input | 1 | bus select, active low |
| rs | input | 1 | 0: index/status, 1: indexed register |
| wr_n | input | 1 | write strobe, rising edge takes the byte |
| rd_n | input | 1 | read strobe, low while the byte is driven |
| db_in | input | 8 | bus byte from the host |
| db_out | output | 8 | bus byte to the host |
| db_oe | output | 1 | enable for the bus drivers |
| raster_row | input | 8 | current raster line from panel timing |
| fb_we | output | 1 | frame-buffer write strobe |
| fb_addr | output | 16 | frame-buffer address {vertical, horizontal} |
| fb_wdata | output | 16 | frame-buffer write word |
| fb_bit_en | output | 16 | per-bit write enable |
| fb_rdata | input | 16 | frame-buffer word at `fb_addr` |

## Verification
The counter is driven through an up-counting, horizontal-first run in a 2x2 window that wraps both axes and returns to its start cell. It is then driven through a down-counting, vertical-first run in the same window. These two runs tell apart the choice of leading axis, each direction bit and the edge each direction treats as its wrap point. An index word with junk in bit 7 and in the high byte, followed by data stores, shows whether only bits [6:0] steer the index. A write with the select high placed between stores, and a frame-buffer read placed between stores, show through the next store's address that neither one moves the counter. Status and register read-backs written with spare bits set show the field packing.

// File: rtl/disp_port_pkg.sv
package disp_port_pkg;
  localparam logic [6:0] IX_DEVCODE  = 7'h00;
  localparam logic [6:0] IX_CONTRAST = 7'h04;
  localparam logic [6:0] IX_SCAN     = 7'h05;
  localparam logic [6:0] IX_HWIN     = 7'h16;
  localparam logic [6:0] IX_VWIN     = 7'h17;
  localparam logic [6:0] IX_WMASK    = 7'h20;
  localparam logic [6:0] IX_ADDR     = 7'h21;
  localparam logic [6:0] IX_GRAM     = 7'h22;
  localparam logic [15:0] DEVICE_ID  = 16'h0766;

  typedef struct packed {
    logic [1:0] dir;         // [1] vertical up, [0] horizontal up
    logic       vert_first;  // 1: vertical axis leads
  } scan_mode_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] din,
  output logic          wr_rise,
  output logic          rd_rise,
  output logic          rd_active,
  output logic          rs_q,
  output logic [DW-1:0] dq
);
  // control vector order: {cs, rs, wr, rd}
  logic [3:0]    ctl_s1, ctl_s2;
  logic [1:0]    strb_s3;
  logic [DW-1:0] d_s1, d_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1  <= 4'b1011;
      ctl_s2  <= 4'b1011;
      strb_s3 <= 2'b11;
      d_s1    <= '0;
      d_s2    <= '0;
    end else begin
      ctl_s1  <= {cs_n, rs, wr_n, rd_n};
      ctl_s2  <= ctl_s1;
      strb_s3 <= ctl_s2[1:0];
      d_s1    <= din;
      d_s2    <= d_s1;
    end
  end

  assign wr_rise   = ctl_s2[1] & ~strb_s3[1] & ~ctl_s2[3];
  assign rd_rise   = ctl_s2[0] & ~strb_s3[0] & ~ctl_s2[3];
  assign rd_active = ~ctl_s2[3] & ~ctl_s2[0];
  assign rs_q      = ctl_s2[2];
  assign dq        = d_s2;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import disp_port_pkg::*;
#(
  parameter int XW = 8,
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic          reg_we,
  input  logic [15:0]   word,
  output logic [6:0]    idx,
  output logic [6:0]    contrast,
  output logic [2:0]    vreg,
  output scan_mode_t    mode,
  output logic [XW-1:0] hs,
  output logic [XW-1:0] he,
  output logic [YW-1:0] vs,
  output logic [YW-1:0] ve,
  output logic [15:0]   wmask
);
  logic [6:0]    idx_d, contrast_d;
  logic [2:0]    vreg_d;
  scan_mode_t    mode_d;
  logic [XW-1:0] hs_d, he_d;
  logic [YW-1:0] vs_d, ve_d;
  logic [15:0]   wmask_d;

  always_comb begin
    idx_d      = idx;
    contrast_d = contrast;
    vreg_d     = vreg;
    mode_d     = mode;
    hs_d       = hs;
    he_d       = he;
    vs_d       = vs;
    ve_d       = ve;
    wmask_d    = wmask;
    if (idx_we) idx_d = word[6:0];
    if (reg_we) begin
      unique case (idx)
        IX_CONTRAST: begin
          contrast_d = word[6:0];
          vreg_d     = word[10:8];
        end
        IX_SCAN: begin
          mode_d.dir        = word[5:4];
          mode_d.vert_first = word[3];
        end
        IX_HWIN: begin
          hs_d = word[0+:XW];
          he_d = word[8+:XW];
        end
        IX_VWIN: begin
          vs_d = word[0+:YW];
          ve_d = word[8+:YW];
        end
        IX_WMASK: wmask_d = word;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      contrast <= '0;
      vreg     <= '0;
      mode     <= '{dir: 2'b11, vert_first: 1'b0};
      hs       <= '0;
      he       <= '1;
      vs       <= '0;
      ve       <= '1;
      wmask    <= '0;
    end else begin
      idx      <= idx_d;
      contrast <= contrast_d;
      vreg     <= vreg_d;
      mode     <= mode_d;
      hs       <= hs_d;
      he       <= he_d;
      vs       <= vs_d;
      ve       <= ve_d;
      wmask    <= wmask_d;
    end
  end
endmodule

// File: rtl/win_addr_ctr.sv
module win_addr_ctr
  import disp_port_pkg::*;
#(
  parameter  int XW = 8,
  parameter  int YW = 8,
  localparam int AW = XW + YW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  scan_mode_t    mode,
  input  logic [XW-1:0] hs,
  input  logic [XW-1:0] he,
  input  logic [YW-1:0] vs,
  input  logic [YW-1:0] ve,
  output logic [AW-1:0] addr
);
  logic [XW-1:0] x_q, x_d, x_adv;
  logic [YW-1:0] y_q, y_d, y_adv;
  logic          x_edge, y_edge;

  always_comb begin
    // candidate move of each axis, wrapping at the edge it heads toward
    x_edge = mode.dir[0] ? (x_q == he) : (x_q == hs);
    y_edge = mode.dir[1] ? (y_q == ve) : (y_q == vs);
    if (x_edge)           x_adv = mode.dir[0] ? hs : he;
    else if (mode.dir[0]) x_adv = x_q + 1'b1;
    else                  x_adv = x_q - 1'b1;
    if (y_edge)           y_adv = mode.dir[1] ? vs : ve;
    else if (mode.dir[1]) y_adv = y_q + 1'b1;
    else                  y_adv = y_q - 1'b1;

    x_d = x_q;
    y_d = y_q;
    if (load) begin
      x_d = load_val[0+:XW];
      y_d = load_val[XW+:YW];
    end else if (step) begin
      if (mode.vert_first) begin
        y_d = y_adv;
        if (y_edge) x_d = x_adv;
      end else begin
        x_d = x_adv;
        if (x_edge) y_d = y_adv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign addr = {y_q, x_q};
endmodule

// File: rtl/disp_reg_port.sv
module disp_reg_port
  import disp_port_pkg::*;
#(
  parameter  int XW = 8,
  parameter  int YW = 8,
  localparam int AW = XW + YW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [7:0]    db_in,
  output logic [7:0]    db_out,
  output logic          db_oe,
  input  logic [7:0]    raster_row,
  output logic          fb_we,
  output logic [AW-1:0] fb_addr,
  output logic [15:0]   fb_wdata,
  output logic [15:0]   fb_bit_en,
  input  logic [15:0]   fb_rdata
);
  // reset: asserted at once, released on the clock
  logic [1:0] rst_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  logic       wr_rise, rd_rise, rd_active, rs_q;
  logic [7:0] dq;

  bus_sync #(.DW(8)) u_sync (
    .clk(clk), .rst_n(srst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n), .rd_n(rd_n),
    .din(db_in), .wr_rise(wr_rise), .rd_rise(rd_rise), .rd_active(rd_active),
    .rs_q(rs_q), .dq(dq)
  );

  // byte pairing
  logic        phase_q, phase_d;
  logic [7:0]  hi_q, hi_d;
  logic [15:0] hold_q, hold_d, rdw, word;
  logic        commit, idx_we, reg_we, ac_load, gram_we;

  assign word    = {hi_q, dq};
  assign commit  = wr_rise & phase_q;
  assign idx_we  = commit & ~rs_q;
  assign reg_we  = commit & rs_q;

  logic [6:0]    idx, contrast;
  logic [2:0]    vreg;
  scan_mode_t    mode;
  logic [XW-1:0] hs, he;
  logic [YW-1:0] vs, ve;
  logic [15:0]   wmask;

  cfg_regs #(.XW(XW), .YW(YW)) u_regs (
    .clk(clk), .rst_n(srst_n), .idx_we(idx_we), .reg_we(reg_we), .word(word),
    .idx(idx), .contrast(contrast), .vreg(vreg), .mode(mode),
    .hs(hs), .he(he), .vs(vs), .ve(ve), .wmask(wmask)
  );

  assign ac_load = reg_we & (idx == IX_ADDR);
  assign gram_we = reg_we & (idx == IX_GRAM);

  logic          we_q, we_d;
  logic [15:0]   wdat_q, wdat_d, ben_q, ben_d;
  logic [AW-1:0] ac;

  win_addr_ctr #(.XW(XW), .YW(YW)) u_ctr (
    .clk(clk), .rst_n(srst_n), .load(ac_load), .load_val(word[AW-1:0]),
    .step(we_q), .mode(mode), .hs(hs), .he(he), .vs(vs), .ve(ve), .addr(ac)
  );

  // read word selection
  always_comb begin
    rdw = '0;
    if (!rs_q) begin
      rdw[15:8] = raster_row;
      rdw[6:0]  = contrast;
    end else begin
      unique case (idx)
        IX_DEVCODE:  rdw = DEVICE_ID;
        IX_CONTRAST: begin
          rdw[10:8] = vreg;
          rdw[6:0]  = contrast;
        end
        IX_SCAN: begin
          rdw[5:4] = mode.dir;
          rdw[3]   = mode.vert_first;
        end
        IX_HWIN: begin
          rdw[8+:XW] = he;
          rdw[0+:XW] = hs;
        end
        IX_VWIN: begin
          rdw[8+:YW] = ve;
          rdw[0+:YW] = vs;
        end
        IX_WMASK: rdw = wmask;
        IX_GRAM:  rdw = fb_rdata;
        default:  rdw = '0;
      endcase
    end
  end

  always_comb begin
    phase_d = phase_q;
    hi_d    = hi_q;
    hold_d  = hold_q;
    we_d    = gram_we;
    wdat_d  = wdat_q;
    ben_d   = ben_q;
    if (wr_rise || rd_rise) phase_d = ~phase_q;
    if (wr_rise && !phase_q) hi_d = dq;
    if (rd_rise && !phase_q) hold_d = rdw;
    if (gram_we) begin
      wdat_d = word;
      ben_d  = ~wmask;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= 1'b0;
      hi_q    <= '0;
      hold_q  <= '0;
      we_q    <= 1'b0;
      wdat_q  <= '0;
      ben_q   <= '0;
    end else begin
      phase_q <= phase_d;
      hi_q    <= hi_d;
      hold_q  <= hold_d;
      we_q    <= we_d;
      wdat_q  <= wdat_d;
      ben_q   <= ben_d;
    end
  end

  assign db_oe     = rd_active;
  assign db_out    = !rd_active ? 8'h00 : (phase_q ? hold_q[7:0] : rdw[15:8]);
  assign fb_we     = we_q;
  assign fb_addr   = ac;
  assign fb_wdata  = wdat_q;
  assign fb_bit_en = ben_q;
endmodule

// File: rtl/disp_port_chk.sv
module disp_port_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic [7:0]    db_out,
  input logic          db_oe,
  input logic          fb_we,
  input logic [AW-1:0] fb_addr,
  input logic [15:0]   fb_wdata
);
  // R2
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |=> !fb_we);

  // R6
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_we |-> $stable(fb_wdata));

  // R13
  oe_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |-> (!$past(cs_n, 2) && !$past(rd_n, 2)));

  // R13
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !db_oe |-> (db_out == 8'h00));

  // R12
  we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_we) |-> !$past(cs_n, 3));
endmodule

bind disp_reg_port disp_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .db_out(db_out),
  .db_oe(db_oe), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata)
);

// File: tb/disp_reg_port_tb.sv
module disp_reg_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, rs, wr_n, rd_n;
  logic [7:0]  db_in, db_out, raster_row;
  logic        db_oe, fb_we;
  logic [15:0] fb_addr, fb_wdata, fb_bit_en, fb_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .wr_n(wr_n), .rd_n(rd_n),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .raster_row(raster_row),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_bit_en(fb_bit_en), .fb_rdata(fb_rdata)
  );

  // external frame buffer stand-in: word derived from its address
  function automatic logic [15:0] ram_word(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction
  assign fb_rdata = ram_word(fb_addr);

  int  checks = 0, fails = 0, cyc = 0;
  bit  run = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference state
  int m_idx = 0, m_ct = 0, m_vr = 0, m_dir = 3, m_am = 0;
  int m_hs = 0, m_he = 255, m_vs = 0, m_ve = 255, m_mask = 0, m_ac = 0;
  int          q_t[$];
  logic [15:0] q_a[$], q_d[$], q_m[$];

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void step_ac();
    int x = m_ac % 256, y = m_ac / 256;
    bit xi = (m_dir % 2) == 1, yi = (m_dir / 2) == 1;
    bit xe = xi ? (x == m_he) : (x == m_hs);
    bit ye = yi ? (y == m_ve) : (y == m_vs);
    int xn = xe ? (xi ? m_hs : m_he) : (xi ? x + 1 : x - 1);
    int yn = ye ? (yi ? m_vs : m_ve) : (yi ? y + 1 : y - 1);
    if (m_am == 0) begin
      x = xn;
      if (xe) y = yn;
    end else begin
      y = yn;
      if (ye) x = xn;
    end
    m_ac = y * 256 + x;
  endfunction

  function automatic void model_commit(bit r, logic [15:0] w, int t);
    if (!r) m_idx = w[6:0];
    else case (m_idx)
      'h04: begin m_ct = w[6:0]; m_vr = w[10:8]; end
      'h05: begin m_dir = w[5:4]; m_am = w[3]; end
      'h16: begin m_hs = w[7:0]; m_he = w[15:8]; end
      'h17: begin m_vs = w[7:0]; m_ve = w[15:8]; end
      'h20: m_mask = w;
      'h21: m_ac = w;
      'h22: begin
        q_t.push_back(t + 3);
        q_a.push_back(m_ac[15:0]);
        q_d.push_back(w);
        q_m.push_back(~m_mask[15:0]);
        step_ac();
      end
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] model_read(bit r);
    if (!r) return {raster_row, 1'b0, m_ct[6:0]};
    case (m_idx)
      'h00: return 16'h0766;
      'h04: return {5'b0, m_vr[2:0], 1'b0, m_ct[6:0]};
      'h05: return {10'b0, m_dir[1:0], m_am[0], 3'b0};
      'h16: return {m_he[7:0], m_hs[7:0]};
      'h17: return {m_ve[7:0], m_vs[7:0]};
      'h20: return m_mask[15:0];
      'h22: return ram_word(m_ac[15:0]);
      default: return 16'h0000;
    endcase
  endfunction

  task automatic put_byte(bit r, logic [7:0] b, bit sel, output int rise);
    @(negedge clk);
    cs_n = !sel; rs = r; db_in = b; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    rise = cyc;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_wr(bit r, logic [15:0] w, bit sel = 1'b1);
    int t;
    put_byte(r, w[15:8], sel, t);
    put_byte(r, w[7:0], sel, t);
    cs_n = 1'b1;
    if (sel) model_commit(r, w, t);
  endtask

  task automatic bus_rd(bit r, string req);
    logic [15:0] got;
    logic [15:0] exp = model_read(r);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      cs_n = 1'b0; rs = r; rd_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R13 db_oe during read", {15'b0, db_oe}, 16'h0001);
      if (i == 0) got[15:8] = db_out; else got[7:0] = db_out;
      rd_n = 1'b1;
      repeat (3) @(negedge clk);
    end
    cs_n = 1'b1;
    chk(req, got, exp);
  endtask

  // per-clock comparison of the frame-buffer port and idle bus
  always @(negedge clk) begin
    if (run) begin
      if (q_t.size() > 0 && q_t[0] == cyc) begin
        chk("R2 R6 fb_we", {15'b0, fb_we}, 16'h0001);
        chk("R6 R7 R8 R9 R10 fb_addr", fb_addr, q_a[0]);
        chk("R6 fb_wdata", fb_wdata, q_d[0]);
        chk("R6 fb_bit_en", fb_bit_en, q_m[0]);
        void'(q_t.pop_front()); void'(q_a.pop_front());
        void'(q_d.pop_front()); void'(q_m.pop_front());
      end else begin
        chk("R2 R12 no stray fb_we", {15'b0, fb_we}, 16'h0000);
      end
      if (!db_oe) chk("R13 idle db_out", {8'h00, db_out}, 16'h0000);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rs = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
    db_in = 8'h00; raster_row = 8'h9C;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 fb_we", {15'b0, fb_we}, 16'h0000);
    chk("R1 fb_addr", fb_addr, 16'h0000);
    chk("R1 db_oe", {15'b0, db_oe}, 16'h0000);
    chk("R1 db_out", {8'h00, db_out}, 16'h0000);
    run = 1;

    bus_wr(0, 16'h0000);
    bus_rd(1, "R5 device code");
    bus_rd(0, "R4 status reset contrast");
    bus_wr(0, 16'h0005);
    bus_rd(1, "R1 R8 scan mode reset");
    bus_wr(0, 16'h0016);
    bus_rd(1, "R1 R9 window reset");

    // R11 contrast packing, R4 status reflects it
    bus_wr(0, 16'h0004);
    bus_wr(1, 16'hFDAA);
    bus_rd(1, "R11 contrast readback");
    bus_rd(0, "R4 status with contrast");

    // window 2..3 x 4..5, mask, counter
    bus_wr(0, 16'h0016); bus_wr(1, 16'h0302);
    bus_rd(1, "R9 hwin readback");
    bus_wr(0, 16'h0017); bus_wr(1, 16'h0504);
    bus_rd(1, "R9 vwin readback");
    bus_wr(0, 16'h0020); bus_wr(1, 16'h00F0);
    bus_rd(1, "R11 mask readback");
    bus_wr(0, 16'h0021); bus_wr(1, 16'h0402);

    // R3: junk in bit 7 and high byte, index must become 0x22
    bus_wr(0, 16'hFFA2);
    for (int k = 1; k <= 5; k++) bus_wr(1, 16'h1111 * k[15:0]);   // R8 R9

    // R10 vertical-first, counting down
    bus_wr(0, 16'h0005); bus_wr(1, 16'h0008);
    bus_rd(1, "R10 scan readback");
    bus_wr(0, 16'h0021); bus_wr(1, 16'h0503);
    bus_wr(0, 16'h0022);
    for (int k = 0; k < 5; k++) bus_wr(1, 16'hA000 + k[15:0]);

    // R12 deselected write ignored, next store keeps the sequence
    bus_wr(1, 16'hDEAD, 1'b0);
    bus_wr(1, 16'hBEEF);
    // R11 frame-buffer read, counter not moved
    bus_rd(1, "R11 frame buffer read");
    bus_wr(1, 16'hC0DE);

    repeat (10) @(negedge clk);
    chk("R2 all stores seen", q_t.size(), 16'h0000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule